// File: doc/BRIEF.md
# Soft-Decision Four-State Viterbi Decoder

This block decodes a rate-1/2, constraint-length-3 convolutional code from quantized soft channel values. Each accepted input beat carries two unsigned soft values, one for each code bit of a trellis step. For every beat the block computes four branch metrics, updates four path metrics with add-compare-select, and stores one decision bit per state. The blocks it expects end in zero tail bits. When a beat marked end-of-block is accepted, it traces back from state 0 through the stored decisions and emits the decoded bits, tail included, in their original order.

A branch distance is either the soft value itself or its bitwise complement. The expected code bit picks which one, so the datapath needs neither a subtractor nor a multiplier. After each step, path metrics are rebased so that the smallest is zero. A single block can be as long as `MAX_LEN` trellis steps.

Top module: `vit_dec`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low, and they stay low until a block has been accepted and traced back.
- R2: The code uses state bits m1 (previous input) and m2 (the input before that). It emits c0 = u^m2 on `in_y0` and c1 = u^m1^m2 on `in_y1`. A soft value of 0 is a confident 0 and 2^SOFT_W-1 is a confident 1. An error-free, zero-terminated block is decoded exactly, tail bits included.
- R3: The branch distance for a soft value y is y when the expected bit is 0 and ~y when it is 1. The metric of a transition is the sum of the two distances, and each state keeps its smaller candidate. Strong flips of single soft values, spaced at least 9 steps apart, are corrected.
- R4: A mid-scale soft value (2^(SOFT_W-1)-1) in place of a code bit on every fourth step still decodes correctly.
- R5: A block of L accepted beats yields exactly L bits on `out_bit`, in input order, with `out_valid` high on L consecutive cycles and `out_last` high only on the final one.
- R6: Block lengths from 1 (`in_sof` and `in_eof` on the same beat) up to `MAX_LEN` beats are decoded.
- R7: After reset and after every accepted beat, the smallest path metric is 0 and none exceeds 2^(SOFT_W+2)+2*(2^SOFT_W-1). A full-length noisy block still decodes.
- R8: Beats are ignored while a block is being traced back or emitted, even if they carry `in_sof`. Beats without `in_sof` are ignored when no block is open.
- R9: A beat with `in_sof` inside an open block discards that block and starts a new one with fresh metrics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat qualifier |
| in_sof | input | 1 | Beat is the first trellis step of a block |
| in_eof | input | 1 | Beat is the last trellis step of a block |
| in_y0 | input | SOFT_W | Soft value for code bit c0 |
| in_y1 | input | SOFT_W | Soft value for code bit c1 |
| out_valid | output | 1 | Decoded bit qualifier |
| out_bit | output | 1 | Decoded bit, in original order |
| out_last | output | 1 | Final decoded bit of the block |

## Verification
A wrong decision bit or a bad metric update does not show up at the ports until the block ends. It appears about L cycles after the end-of-block beat, as wrong decoded bits near the affected step. A decoder that picks the wrong predecessor on ties or misroutes a branch metric can still decode clean blocks, so the noisy and erased blocks are the ones that expose it. A metric that is not rebased overflows only on long blocks, so a full-length block is included. Faults in the phase control show up as a missing `out_last`, a wrong bit count or gaps in `out_valid`, and they show up on the first block.

// File: rtl/vit_pkg.sv
package vit_pkg;

    localparam int unsigned NS = 4;

    typedef enum logic [1:0] {
        TR_IDLE,
        TR_BACK,
        TR_EMIT
    } tr_phase_t;

    // Trellis state: st[1] = previous input, st[0] = input before that.
    function automatic logic [1:0] code_pair(input logic [1:0] st, input logic u);
        logic [1:0] c;
        c[0] = u ^ st[0];
        c[1] = u ^ st[1] ^ st[0];
        return c;
    endfunction

    function automatic logic [1:0] pred_state(input logic [1:0] ns, input logic d);
        return {ns[0], d};
    endfunction

endpackage

// File: rtl/vit_bmu.sv
module vit_bmu
    import vit_pkg::*;
#(
    parameter int unsigned SOFT_W = 3,
    localparam int unsigned BMW = SOFT_W + 1
) (
    input  logic [SOFT_W-1:0]        y0,
    input  logic [SOFT_W-1:0]        y1,
    output logic [NS-1:0][BMW-1:0]   bm
);

    // Entry c holds the metric for expected code pair c (c[0] on y0).
    for (genvar c = 0; c < NS; c++) begin : g_cw
        localparam logic B0 = 1'(c % 2);
        localparam logic B1 = 1'(c / 2);
        logic [SOFT_W-1:0] d0, d1;
        always_comb begin
            d0 = B0 ? ~y0 : y0;
            d1 = B1 ? ~y1 : y1;
            bm[c] = BMW'(d0) + BMW'(d1);
        end
    end

endmodule

// File: rtl/vit_acs.sv
module vit_acs
    import vit_pkg::*;
#(
    parameter int unsigned BMW = 4,
    parameter int unsigned MW  = 7
) (
    input  logic [NS-1:0][MW-1:0]  pm_in,
    input  logic [NS-1:0][BMW-1:0] bm,
    output logic [NS-1:0][MW-1:0]  pm_out,
    output logic [NS-1:0]          dec
);

    logic [NS-1:0][MW-1:0] raw;
    logic [MW-1:0]         floor_v;

    for (genvar s = 0; s < NS; s++) begin : g_state
        localparam logic [1:0] NSX = 2'(s);
        localparam logic       U   = NSX[1];
        logic [1:0]    p0, p1, cw0, cw1;
        logic [MW-1:0] cand0, cand1;
        always_comb begin
            p0    = pred_state(NSX, 1'b0);
            p1    = pred_state(NSX, 1'b1);
            cw0   = code_pair(p0, U);
            cw1   = code_pair(p1, U);
            cand0 = pm_in[p0] + MW'(bm[cw0]);
            cand1 = pm_in[p1] + MW'(bm[cw1]);
            dec[s] = cand1 < cand0;
            raw[s] = dec[s] ? cand1 : cand0;
        end
    end

    always_comb begin
        floor_v = raw[0];
        for (int i = 1; i < NS; i++) begin
            if (raw[i] < floor_v) floor_v = raw[i];
        end
        for (int i = 0; i < NS; i++) begin
            pm_out[i] = raw[i] - floor_v;
        end
    end

endmodule

// File: rtl/vit_trace.sv
module vit_trace
    import vit_pkg::*;
#(
    parameter int unsigned MAX_LEN = 64,
    localparam int unsigned LW = $clog2(MAX_LEN + 1),
    localparam int unsigned AW = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [NS-1:0] wr_dec,
    input  logic          start,
    input  logic [LW-1:0] start_len,
    output logic          busy,
    output logic          out_valid,
    output logic          out_bit,
    output logic          out_last
);

    logic [NS-1:0]      dmem [MAX_LEN];
    logic [MAX_LEN-1:0] obuf;
    tr_phase_t          ph;
    logic [LW-1:0]      ptr, len;
    logic [1:0]         st;

    always_ff @(posedge clk) begin
        if (wr_en) dmem[wr_addr] <= wr_dec;
    end

    // Bits come out of the traceback last-first; park them by step index.
    always_ff @(posedge clk) begin
        if (ph == TR_BACK) obuf[ptr[AW-1:0]] <= st[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= TR_IDLE;
            ptr       <= '0;
            len       <= '0;
            st        <= '0;
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            unique case (ph)
                TR_IDLE: begin
                    if (start) begin
                        len <= start_len;
                        ptr <= start_len - 1'b1;
                        st  <= '0;
                        ph  <= TR_BACK;
                    end
                end
                TR_BACK: begin
                    st <= pred_state(st, dmem[ptr[AW-1:0]][st]);
                    if (ptr == '0) ph <= TR_EMIT;
                    else           ptr <= ptr - 1'b1;
                end
                TR_EMIT: begin
                    out_valid <= 1'b1;
                    out_bit   <= obuf[ptr[AW-1:0]];
                    out_last  <= (ptr == len - 1'b1);
                    if (ptr == len - 1'b1) ph  <= TR_IDLE;
                    else                   ptr <= ptr + 1'b1;
                end
                default: ph <= TR_IDLE;
            endcase
        end
    end

    assign busy = (ph != TR_IDLE);

endmodule

// File: rtl/vit_dec.sv
module vit_dec
    import vit_pkg::*;
#(
    parameter int unsigned SOFT_W  = 3,
    parameter int unsigned MAX_LEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [SOFT_W-1:0] in_y0,
    input  logic [SOFT_W-1:0] in_y1,
    output logic              out_valid,
    output logic              out_bit,
    output logic              out_last
);

    localparam int unsigned BMW   = SOFT_W + 1;
    localparam int unsigned MW    = BMW + 3;
    localparam int unsigned INF   = 2 ** (MW - 2);
    localparam int unsigned BMMAX = 2 * (2 ** SOFT_W - 1);
    localparam int unsigned LW    = $clog2(MAX_LEN + 1);
    localparam int unsigned AW    = $clog2(MAX_LEN);

    logic [NS-1:0][MW-1:0]  pm_q, pm_init, pm_src, pm_nx;
    logic [NS-1:0][BMW-1:0] bm;
    logic [NS-1:0]          dec;
    logic                   busy, rx_open, accept, wr_en;
    logic [LW-1:0]          cnt, wr_idx, start_len;

    always_comb begin
        for (int i = 0; i < NS; i++) pm_init[i] = (i == 0) ? '0 : MW'(INF);
    end

    assign accept = in_valid && !busy && (in_sof || rx_open);
    assign pm_src = in_sof ? pm_init : pm_q;
    assign wr_idx = in_sof ? '0 : cnt;
    assign wr_en  = accept && (wr_idx < LW'(MAX_LEN));
    assign start_len = (wr_idx < LW'(MAX_LEN)) ? wr_idx + 1'b1 : LW'(MAX_LEN);

    vit_bmu #(.SOFT_W(SOFT_W)) u_bmu (
        .y0 (in_y0),
        .y1 (in_y1),
        .bm (bm)
    );

    vit_acs #(.BMW(BMW), .MW(MW)) u_acs (
        .pm_in  (pm_src),
        .bm     (bm),
        .pm_out (pm_nx),
        .dec    (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_q    <= pm_init;
            rx_open <= 1'b0;
            cnt     <= '0;
        end else if (accept) begin
            pm_q    <= pm_nx;
            rx_open <= !in_eof;
            cnt     <= start_len;
        end
    end

    vit_trace #(.MAX_LEN(MAX_LEN)) u_trace (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_idx[AW-1:0]),
        .wr_dec    (dec),
        .start     (accept && in_eof),
        .start_len (start_len),
        .busy      (busy),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

endmodule

// File: rtl/vit_chk.sv
module vit_chk
    import vit_pkg::*;
#(
    parameter int unsigned MW  = 7,
    parameter int unsigned LIM = 46
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 out_valid,
    input logic                 out_last,
    input logic                 busy,
    input logic [NS-1:0][MW-1:0] pm
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_last));

    a_r5_last_has_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    a_r5_stream_ends_on_last: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_last));

    a_r7_metric_floor: assert property (@(posedge clk) disable iff (rst)
        (pm[0] == '0) || (pm[1] == '0) || (pm[2] == '0) || (pm[3] == '0));

    a_r7_metric_ceiling: assert property (@(posedge clk) disable iff (rst)
        (pm[0] <= MW'(LIM)) && (pm[1] <= MW'(LIM)) &&
        (pm[2] <= MW'(LIM)) && (pm[3] <= MW'(LIM)));

    a_r8_frozen_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(pm));

endmodule

bind vit_dec vit_chk #(.MW(MW), .LIM(INF + BMMAX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_last  (out_last),
    .busy      (busy),
    .pm        (pm_q)
);

// File: tb/tb_vit_dec.sv
module tb_vit_dec;

    localparam int SW   = 3;
    localparam int ML   = 64;
    localparam int YMAX = 2 ** SW - 1;
    localparam int YMID = 2 ** (SW - 1) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [SW-1:0] in_y0 = '0, in_y1 = '0;
    logic out_valid, out_bit, out_last;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit exp_bits [ML];

    vit_dec #(.SOFT_W(SW), .MAX_LEN(ML)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_y0(in_y0), .in_y1(in_y1),
        .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_y0 = '0; in_y1 = '0;
    endtask

    // pattern: 0 random, 1 zeros, 2 alternating; err: 0 clean, 1 flips, 2 mid-scale
    task automatic send_block(input int len, input int pattern, input int err);
        bit m1 = 1'b0, m2 = 1'b0;
        for (int i = 0; i < len; i++) begin
            bit u, c0, c1;
            int s0, s1;
            if (i >= len - 2)      u = 1'b0;
            else if (pattern == 0) u = 1'($urandom % 2);
            else if (pattern == 1) u = 1'b0;
            else                   u = 1'(i % 2);
            exp_bits[i] = u;
            c0 = u ^ m2;
            c1 = u ^ m1 ^ m2;
            m2 = m1;
            m1 = u;
            s0 = c0 ? YMAX : 0;
            s1 = c1 ? YMAX : 0;
            if (err == 1 && i % 9 == 4) s0 = YMAX - s0;
            if (err == 2 && i % 4 == 1) s1 = YMID;
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_y0    = SW'(s0);
            in_y1    = SW'(s1);
        end
        @(negedge clk);
        idle_inputs();
    endtask

    // Gather one block of output; optionally hammer inputs meanwhile.
    task automatic collect(input string req, input int len, input bit noise);
        int n = 0, mism = 0, gaps = 0, lim = 0;
        bit started = 1'b0, done = 1'b0;
        while (!done && lim < 4 * ML + 40) begin
            lim++;
            if (out_valid) begin
                started = 1'b1;
                if (n < ML && out_bit != exp_bits[n]) mism++;
                n++;
                if (out_last) done = 1'b1;
            end else if (started) begin
                gaps++;
            end
            if (!done && noise) begin
                in_valid = 1'b1;
                in_sof   = 1'($urandom % 2);
                in_eof   = 1'($urandom % 2);
                in_y0    = SW'($urandom);
                in_y1    = SW'($urandom);
            end
            if (!done) @(negedge clk);
        end
        idle_inputs();
        check({req, " R5 bit count"}, n, len);
        check({req, " mismatching bits"}, mism, 0);
        check({req, " R5 gaps in out_valid"}, gaps, 0);
    endtask

    task automatic t_reset();
        int seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (out_valid || out_last) seen++;
        end
        check("R1 output after reset", seen, 0);
    endtask

    task automatic t_clean();
        send_block(20, 0, 0); collect("R2 clean random", 20, 1'b0);
        send_block(16, 1, 0); collect("R2 all-zero", 16, 1'b0);
        send_block(25, 2, 0); collect("R2 alternating", 25, 1'b0);
    endtask

    task automatic t_flips();
        send_block(40, 0, 1); collect("R3 isolated flips", 40, 1'b0);
    endtask

    task automatic t_mid();
        send_block(30, 0, 2); collect("R4 mid-scale values", 30, 1'b0);
    endtask

    task automatic t_lengths();
        send_block(1, 0, 0);  collect("R6 single beat", 1, 1'b0);
        send_block(ML, 0, 1); collect("R6 R7 full length noisy", ML, 1'b0);
    endtask

    task automatic t_ignored();
        int seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 9);
            in_y0 = SW'($urandom); in_y1 = SW'($urandom);
        end
        @(negedge clk);
        idle_inputs();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check("R8 beats without sof while idle", seen, 0);
        send_block(24, 0, 0); collect("R8 inputs during decode", 24, 1'b1);
        send_block(18, 0, 0); collect("R8 block after noise", 18, 1'b0);
    endtask

    task automatic t_restart();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = 1'b0;
            in_y0 = SW'($urandom); in_y1 = SW'($urandom);
        end
        send_block(22, 0, 1); collect("R9 sof restarts block", 22, 1'b0);
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clean();
        t_flips();
        t_mid();
        t_lengths();
        t_ignored();
        t_restart();
        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule